// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. A frame starts with a low start bit. It carries 5 to 8 data bits, least significant bit first. An optional parity bit follows the data, and the frame ends with a high stop interval whose length can be set. Every bit period is counted in pulses of a baud tick that runs at sixteen times the bit rate, so the divisor that makes the tick sits outside this block.

A writer loads characters through a one-entry holding register. The block takes the held character into its shifter as soon as the shifter is free. Two status outputs show when the holding register can take another character and when the whole transmitter has gone quiet. The line format is set by live control inputs: data length, parity enable, even/odd select, stick parity, stop-bit select and break. The format is captured each time a character moves into the shifter. Break is the one exception: it acts at once on the line.

Top module: `uart_frame_tx`

## Requirements
- R1: `len_sel` selects the number of data bits per frame: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Data bits are sent least significant bit first, and any unused upper bits of `wr_data` are not sent.
- R2: The line is high when idle. A frame begins with one start bit at 0, and the start bit and every data and parity bit last exactly `BIT_TICKS` (16) baud ticks.
- R3: When `par_en` is 1 and `par_stick` is 0, a parity bit is placed between the last data bit and the stop interval. With `par_even` = 0 the data bits and parity bit together hold an odd number of ones. With `par_even` = 1 they hold an even number. When `par_en` is 0, no parity bit is sent.
- R4: When `par_en` and `par_stick` are both 1, the parity bit is constant: 0 if `par_even` is 1 and 1 if `par_even` is 0.
- R5: The stop interval is high. It lasts 16 ticks when `stop_sel` is 0, 24 ticks when `stop_sel` is 1 with 5-bit characters, and 32 ticks when `stop_sel` is 1 with 6, 7 or 8-bit characters.
- R6: While `brk` is 1, `txd` is 0. Frame timing and both status flags go on unchanged, and the line shows the normal frame level again in the first cycle after `brk` drops.
- R7: `hold_empty` goes low in the cycle after a write. It goes high again in the cycle after the held character moves into the shifter. A write to a full holding register replaces its contents.
- R8: `tx_empty` is 1 only when the holding register is empty and no frame is in progress. It goes high in the cycle after the last stop tick of the last frame.
- R9: A character written while a frame is in progress is loaded on the clock edge that ends the current stop interval, so the next start bit follows with no idle gap. A character written to an idle transmitter starts one clock after the write.
- R10: The format inputs (`len_sel`, `par_en`, `par_even`, `par_stick`, `stop_sel`) are sampled when a character is loaded into the shifter. Changing them during a frame has no effect on that frame.
- R11: After reset, `txd` is 1 and both `hold_empty` and `tx_empty` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | 8 | Character to send |
| len_sel | input | 2 | Data length select |
| par_en | input | 1 | Parity enable |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Stick parity enable |
| stop_sel | input | 1 | Long stop interval select |
| brk | input | 1 | Force the line low |
| txd | output | 1 | Serial output |
| hold_empty | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register and shifter both idle |

## Verification
Almost every internal fault shows up on `txd`. A wrong bit counter, a wrong tick limit or a wrong parity term changes the line level or shifts a bit edge. That difference appears within one bit period, or at the latest when the stop interval ends early or late. Holding-register faults show on `hold_empty` and `tx_empty` one clock after the write or load that exposes them. A lost or duplicated character also makes a whole frame appear or go missing on the line. The reference model follows each frame as a list of level and duration segments, and the bench compares all three outputs with it on every clock, so a mismatch is reported in the cycle it appears.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int BIT_TICKS = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    len_sel,
  input  logic          par_en,
  input  logic          par_even,
  input  logic          par_stick,
  input  logic          stop_sel,
  input  logic          brk,
  output logic          txd,
  output logic          hold_empty,
  output logic          tx_empty
);
  localparam int CW = $clog2(2 * BIT_TICKS + 1);
  localparam logic [CW-1:0] ONE_BIT  = CW'(BIT_TICKS);
  localparam logic [CW-1:0] ONE_HALF = CW'(BIT_TICKS + BIT_TICKS / 2);
  localparam logic [CW-1:0] TWO_BITS = CW'(2 * BIT_TICKS);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt, lim, fr_stop;
  logic [2:0]    bidx, fr_last;
  logic [DW-1:0] shreg, hold, mask;
  logic          hold_full, fr_pen, fr_pbit;
  logic          last_tick, done, load, line, ones;

  assign mask      = {DW{1'b1}} >> (2'd3 - len_sel);
  assign ones      = ^(hold & mask);
  assign lim       = (st == S_STOP) ? fr_stop : ONE_BIT;
  assign last_tick = baud_tick && (st != S_IDLE) && (cnt == lim - 1'b1);
  assign done      = last_tick && (st == S_STOP);
  assign load      = hold_full && ((st == S_IDLE) || done);

  always_comb begin
    case (st)
      S_START: line = 1'b0;
      S_DATA:  line = shreg[0];
      S_PAR:   line = fr_pbit;
      default: line = 1'b1;
    endcase
  end

  assign txd        = brk ? 1'b0 : line;
  assign hold_empty = !hold_full;
  assign tx_empty   = !hold_full && (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
    end else begin
      if (load)  hold_full <= 1'b0;
      if (wr_en) begin
        hold      <= wr_data;
        hold_full <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      shreg   <= '0;
      fr_last <= 3'd4;
      fr_pen  <= 1'b0;
      fr_pbit <= 1'b0;
      fr_stop <= ONE_BIT;
    end else if (load) begin
      st      <= S_START;
      cnt     <= '0;
      bidx    <= '0;
      shreg   <= hold & mask;
      fr_last <= 3'd4 + {1'b0, len_sel};
      fr_pen  <= par_en;
      fr_pbit <= par_stick ? !par_even : (par_even ? ones : !ones);
      fr_stop <= !stop_sel ? ONE_BIT : (len_sel == 2'b00 ? ONE_HALF : TWO_BITS);
    end else if (done) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (last_tick) begin
      cnt <= '0;
      case (st)
        S_START: st <= S_DATA;
        S_DATA: begin
          shreg <= shreg >> 1;
          bidx  <= bidx + 1'b1;
          if (bidx == fr_last) st <= fr_pen ? S_PAR : S_STOP;
        end
        S_PAR:   st <= S_STOP;
        default: st <= S_IDLE;
      endcase
    end else if (baud_tick && st != S_IDLE) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !brk) |-> txd) else $error("idle line not high");
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START) |-> !txd) else $error("start bit not low");
  // R5
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP && !brk) |-> txd) else $error("stop interval not high");
  // R6
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd) else $error("break not forcing line low");
  // R8
  empty_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> hold_empty) else $error("tx_empty without hold_empty");
  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_empty && !wr_en && !load) |=> !hold_empty) else $error("held character lost");
  // R9
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hold_empty) |=> (st == S_START)) else $error("queued character not started");
  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < lim) else $error("tick counter beyond limit");
endmodule

// File: tb/sim_uart_frame_tx.sv
module sim_uart_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int TPB = 16;

  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] len_sel = '0;
  logic par_en = 0, par_even = 0, par_stick = 0, stop_sel = 0, brk = 0;
  logic txd, hold_empty, tx_empty;

  int errors = 0, checks = 0, cyc = 0, tdiv = 0;
  string cur_req = "R11";

  int q_lvl[$];
  int q_len[$];
  int m_cnt = 0;
  logic [7:0] m_hold = '0;
  bit m_full = 0;

  uart_frame_tx #(.BIT_TICKS(TPB), .DW(8)) u0 (
    .clk, .rst_n, .baud_tick, .wr_en, .wr_data, .len_sel, .par_en,
    .par_even, .par_stick, .stop_sel, .brk, .txd, .hold_empty, .tx_empty);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: got %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  task automatic build_frame(logic [7:0] d);
    int n = 5 + int'(len_sel);
    bit p = 0;
    for (int i = 0; i < n; i++) p ^= d[i];
    q_lvl.push_back(0); q_len.push_back(TPB);
    for (int i = 0; i < n; i++) begin q_lvl.push_back(int'(d[i])); q_len.push_back(TPB); end
    if (par_en) begin
      q_lvl.push_back(par_stick ? int'(!par_even) : (par_even ? int'(p) : int'(!p)));
      q_len.push_back(TPB);
    end
    q_lvl.push_back(1);
    q_len.push_back(!stop_sel ? TPB : (n == 5 ? TPB + TPB/2 : 2*TPB));
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q_lvl.delete(); q_len.delete(); m_cnt = 0; m_full = 0;
    end else begin
      if (q_lvl.size() > 0 && baud_tick) begin
        m_cnt++;
        if (m_cnt == q_len[0]) begin
          void'(q_lvl.pop_front()); void'(q_len.pop_front()); m_cnt = 0;
        end
      end
      if (q_lvl.size() == 0 && m_full) begin
        build_frame(m_hold); m_full = 0; m_cnt = 0;
      end
      if (wr_en) begin m_hold = wr_data; m_full = 1; end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(brk ? "R6" : cur_req, "txd", txd,
          brk ? 1'b0 : (q_lvl.size() > 0 ? logic'(q_lvl[0][0]) : 1'b1));
      chk("R7", "hold_empty", hold_empty, !m_full);
      chk("R8", "tx_empty", tx_empty, !m_full && q_lvl.size() == 0);
    end
    tdiv = (tdiv + 1) % 3;
    baud_tick <= (tdiv == 0);
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d: got hung expected finish", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic cfg(logic [1:0] l, bit pe, bit ev, bit sk, bit sb);
    len_sel = l; par_en = pe; par_even = ev; par_stick = sk; stop_sel = sb;
  endtask

  task automatic put(logic [7:0] d);
    @(negedge clk); wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (!(tx_empty && q_lvl.size() == 0 && !m_full)) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R11";
    chk("R11", "reset txd", txd, 1'b1);
    chk("R11", "reset hold_empty", hold_empty, 1'b1);
    chk("R11", "reset tx_empty", tx_empty, 1'b1);
    rst_n = 1;
    repeat (4) @(negedge clk);

    cur_req = "R1";
    for (int l = 0; l < 4; l++) begin
      cfg(2'(l), 0, 0, 0, 0); put(8'hA7 ^ 8'(l * 37)); drain();
    end
    cur_req = "R2"; cfg(2'b11, 0, 0, 0, 0); put(8'h00); put(8'hFF); drain();
    cur_req = "R3";
    for (int m = 0; m < 4; m++) begin
      cfg(2'(m), 1, m[0], 0, 0); put(8'h35 + 8'(m)); drain();
      cfg(2'(m), 1, !m[0], 0, 0); put(8'h6C - 8'(m)); drain();
    end
    cur_req = "R4";
    cfg(2'b10, 1, 1, 1, 0); put(8'h7F); drain();
    cfg(2'b01, 1, 0, 1, 0); put(8'h00); drain();
    cur_req = "R5";
    cfg(2'b00, 0, 0, 0, 1); put(8'h15); drain();
    cfg(2'b00, 1, 1, 0, 1); put(8'h0A); drain();
    cfg(2'b01, 0, 0, 0, 1); put(8'h2B); drain();
    cfg(2'b11, 1, 0, 0, 1); put(8'hC3); drain();
    cur_req = "R9";
    cfg(2'b11, 0, 0, 0, 0); put(8'h81); put(8'h42); put(8'h5A); drain();
    cur_req = "R7";
    put(8'h11); put(8'h22); put(8'h33); drain();
    cur_req = "R10";
    cfg(2'b11, 1, 0, 0, 1); put(8'h96);
    repeat (40) @(negedge clk);
    cfg(2'b00, 0, 1, 1, 0);
    drain();
    cur_req = "R6";
    cfg(2'b11, 0, 0, 0, 0);
    @(negedge clk); brk = 1;
    put(8'hFF); put(8'h55);
    repeat (300) @(negedge clk); brk = 0;
    drain();
    cur_req = "R8";
    cfg(2'b00, 0, 0, 0, 0); put(8'h1F); drain();
    chk("R8", "final tx_empty", tx_empty, 1'b1);
    chk("R2", "final idle txd", txd, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule